// File: doc/BRIEF.md
# Control-Pin Key Sequence Mode Detector

This block tells a serial LED-sink style driver when to leave ordinary display operation and enter its output fault-check mode, and when to return. The chip has no pin dedicated to selecting the mode. Instead, the detector watches two existing control pins on every rising clock edge: the active-low output enable and the latch strobe. When these pins trace a fixed key over five consecutive edges, the detector changes the mode.

There is one key for entering fault-check mode and a different key for returning to normal mode. The detector compares the incoming pins only against the key that applies to its current mode, so the two transitions always alternate. It keeps a sliding window of the latest pin pairs. It clears that window at reset and again at each mode change, so samples taken before a transition can never help complete the next one.

The outputs are a level flag for the mode and a single-cycle pulse for each kind of transition. How the mode then affects the shift register, latch or outputs is left to the logic that uses these signals.

Top module: `pin_key_mode_detector`

## Requirements
- R1: While `rst` is high at a rising edge, and after it, `check_mode`, `enter_pulse` and `leave_pulse` are 0. No sample taken before or during reset counts toward a key, so a key started before reset and finished after it does not change the mode.
- R2: In normal mode (`check_mode`=0), five consecutive rising-edge samples of (`oe_n`,`le`) equal to (1,0),(0,0),(1,0),(1,1),(1,0), in that order, set `check_mode` to 1. The flag is visible right after the fifth edge, before the sixth edge.
- R3: `enter_pulse` is 1 for exactly the one cycle that follows the edge completing the entry key, and is 0 otherwise.
- R4: In fault-check mode, five consecutive samples of (1,0),(0,0),(1,0),(1,0),(1,0) clear `check_mode` after the fifth edge. `leave_pulse` is 1 for exactly that one following cycle.
- R5: In normal mode the exit key is ignored: `check_mode` stays 0 and neither pulse fires.
- R6: In fault-check mode the entry key is ignored: `check_mode` stays 1 and neither pulse fires.
- R7: A sample that breaks a partly matched key does not stall detection. The key is found in the latest five samples wherever it starts, including a start at the breaking sample itself.
- R8: After a mode change the window is empty. The next transition needs five fresh samples, even when the tail of the previous key would otherwise complete it.
- R9: `enter_pulse` and `leave_pulse` are never 1 in the same cycle. `check_mode` changes only together with its matching pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all pin samples are taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output-enable pin, sampled as key input |
| le | input | 1 | Latch strobe pin, sampled as key input |
| check_mode | output | 1 | 1 while in fault-check mode, 0 in normal mode |
| enter_pulse | output | 1 | One-cycle pulse on entry into fault-check mode |
| leave_pulse | output | 1 | One-cycle pulse on return to normal mode |

## Verification
The bench builds the detector with its default parameters: a key length of five and the two keys given in R2 and R4. These defaults put the cases that matter within a few cycles. The entry key ends with the same pin pair that starts the exit key, so the window flush after a transition can be tested directly. The entry key also contains a prefix that repeats after a break, which exercises restarted matching. With the exit key's latch column all zero, the bench can check that idle stretches in the opposite mode never fire a transition.

// File: rtl/mode_key_pkg.sv
package mode_key_pkg;

    // One sample of the shared control pins.
    typedef struct packed {
        logic oe_n;
        logic le;
    } pin_pair_t;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_CHECK  = 1'b1
    } op_mode_e;

    localparam int unsigned KEY_LEN_DEFAULT = 5;

    // Compare one pin sample against one step of a key.
    function automatic logic step_matches(pin_pair_t s, logic want_oe, logic want_le);
        return (s.oe_n == want_oe) && (s.le == want_le);
    endfunction

endpackage

// File: rtl/pin_history.sv
module pin_history
    import mode_key_pkg::*;
#(
    parameter int unsigned DEPTH = KEY_LEN_DEFAULT - 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  pin_pair_t             sample_i,
    output pin_pair_t [DEPTH-1:0] hist_o,
    output logic                  full_o
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    pin_pair_t [DEPTH-1:0] hist_q;
    logic [CNT_W-1:0]      fill_q;

    // hist_q[0] holds the newest stored sample, hist_q[DEPTH-1] the oldest.
    always_ff @(posedge clk) begin
        hist_q[0] <= sample_i;
        if (rst || flush) begin
            fill_q <= '0;
        end else if (fill_q != CNT_MAX) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_shift
            always_ff @(posedge clk) begin
                hist_q[i] <= hist_q[i-1];
            end
        end
    endgenerate

    assign hist_o = hist_q;
    assign full_o = (fill_q == CNT_MAX);

endmodule

// File: rtl/key_matcher.sv
module key_matcher
    import mode_key_pkg::*;
#(
    parameter int unsigned          KEY_LEN = KEY_LEN_DEFAULT,
    parameter logic [KEY_LEN-1:0]   OE_KEY  = '0,
    parameter logic [KEY_LEN-1:0]   LE_KEY  = '0
) (
    input  pin_pair_t                 current_i,
    input  pin_pair_t [KEY_LEN-2:0]   hist_i,
    input  logic                      hist_full_i,
    output logic                      hit_o
);
    // Key bit KEY_LEN-1 is the first sample, bit 0 is the sample of the current edge.
    logic [KEY_LEN-1:0] step_ok;

    assign step_ok[0] = step_matches(current_i, OE_KEY[0], LE_KEY[0]);

    generate
        for (genvar k = 1; k < KEY_LEN; k++) begin : g_step
            assign step_ok[k] = step_matches(hist_i[k-1], OE_KEY[k], LE_KEY[k]);
        end
    endgenerate

    assign hit_o = hist_full_i && (&step_ok);

endmodule

// File: rtl/mode_sequencer.sv
module mode_sequencer
    import mode_key_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enter_hit,
    input  logic     exit_hit,
    output op_mode_e mode_o,
    output logic     enter_pulse_o,
    output logic     leave_pulse_o,
    output logic     flush_o
);
    op_mode_e mode_q;
    logic     take_enter;
    logic     take_exit;
    logic     en_q;
    logic     lv_q;

    // Only the key belonging to the present mode is honoured.
    always_comb begin
        take_enter = (mode_q == MODE_NORMAL) && enter_hit;
        take_exit  = (mode_q == MODE_CHECK)  && exit_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_NORMAL;
            en_q   <= 1'b0;
            lv_q   <= 1'b0;
        end else begin
            en_q <= take_enter;
            lv_q <= take_exit;
            if (take_enter) begin
                mode_q <= MODE_CHECK;
            end else if (take_exit) begin
                mode_q <= MODE_NORMAL;
            end
        end
    end

    assign mode_o        = mode_q;
    assign enter_pulse_o = en_q;
    assign leave_pulse_o = lv_q;
    assign flush_o       = take_enter || take_exit;

endmodule

// File: rtl/pin_key_mode_detector.sv
module pin_key_mode_detector
    import mode_key_pkg::*;
#(
    parameter int unsigned        KEY_LEN  = KEY_LEN_DEFAULT,
    parameter logic [KEY_LEN-1:0] ENTER_OE = 5'b10111,
    parameter logic [KEY_LEN-1:0] ENTER_LE = 5'b00010,
    parameter logic [KEY_LEN-1:0] EXIT_OE  = 5'b10111,
    parameter logic [KEY_LEN-1:0] EXIT_LE  = 5'b00000
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_n,
    input  logic le,
    output logic check_mode,
    output logic enter_pulse,
    output logic leave_pulse
);
    localparam int unsigned HIST_DEPTH = KEY_LEN - 1;

    pin_pair_t                  sample;
    pin_pair_t [HIST_DEPTH-1:0] hist;
    logic                       hist_full;
    logic                       enter_hit;
    logic                       exit_hit;
    logic                       flush;
    op_mode_e                   mode;

    assign sample.oe_n = oe_n;
    assign sample.le   = le;

    pin_history #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .sample_i (sample),
        .hist_o   (hist),
        .full_o   (hist_full)
    );

    key_matcher #(.KEY_LEN(KEY_LEN), .OE_KEY(ENTER_OE), .LE_KEY(ENTER_LE)) u_enter_match (
        .current_i   (sample),
        .hist_i      (hist),
        .hist_full_i (hist_full),
        .hit_o       (enter_hit)
    );

    key_matcher #(.KEY_LEN(KEY_LEN), .OE_KEY(EXIT_OE), .LE_KEY(EXIT_LE)) u_exit_match (
        .current_i   (sample),
        .hist_i      (hist),
        .hist_full_i (hist_full),
        .hit_o       (exit_hit)
    );

    mode_sequencer u_seq (
        .clk           (clk),
        .rst           (rst),
        .enter_hit     (enter_hit),
        .exit_hit      (exit_hit),
        .mode_o        (mode),
        .enter_pulse_o (enter_pulse),
        .leave_pulse_o (leave_pulse),
        .flush_o       (flush)
    );

    assign check_mode = (mode == MODE_CHECK);

endmodule

// File: rtl/key_mode_checker.sv
module key_mode_checker #(
    parameter int unsigned        KEY_LEN  = 5,
    parameter logic [KEY_LEN-1:0] ENTER_OE = 5'b10111,
    parameter logic [KEY_LEN-1:0] ENTER_LE = 5'b00010,
    parameter logic [KEY_LEN-1:0] EXIT_OE  = 5'b10111,
    parameter logic [KEY_LEN-1:0] EXIT_LE  = 5'b00000
) (
    input logic clk,
    input logic rst,
    input logic oe_n,
    input logic le,
    input logic check_mode,
    input logic enter_pulse,
    input logic leave_pulse
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!check_mode && !enter_pulse && !leave_pulse));

    // R9
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(enter_pulse && leave_pulse));

    // R3
    enter_rise_chk: assert property (@(posedge clk) disable iff (rst)
        enter_pulse |-> (check_mode && !$past(check_mode)));

    // R9
    rise_has_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(check_mode) |-> enter_pulse);

    // R4
    leave_fall_chk: assert property (@(posedge clk) disable iff (rst)
        leave_pulse |-> (!check_mode && $past(check_mode)));

    // R9
    fall_has_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(check_mode) |-> leave_pulse);

    generate
        if (KEY_LEN == 5) begin : g_key5
            // R2
            enter_key_seen_chk: assert property (@(posedge clk) disable iff (rst)
                enter_pulse |->
                    ($past(oe_n, 5) == ENTER_OE[4]) && ($past(le, 5) == ENTER_LE[4]) &&
                    ($past(oe_n, 4) == ENTER_OE[3]) && ($past(le, 4) == ENTER_LE[3]) &&
                    ($past(oe_n, 3) == ENTER_OE[2]) && ($past(le, 3) == ENTER_LE[2]) &&
                    ($past(oe_n, 2) == ENTER_OE[1]) && ($past(le, 2) == ENTER_LE[1]) &&
                    ($past(oe_n, 1) == ENTER_OE[0]) && ($past(le, 1) == ENTER_LE[0]));

            // R4
            exit_key_seen_chk: assert property (@(posedge clk) disable iff (rst)
                leave_pulse |->
                    ($past(oe_n, 5) == EXIT_OE[4]) && ($past(le, 5) == EXIT_LE[4]) &&
                    ($past(oe_n, 4) == EXIT_OE[3]) && ($past(le, 4) == EXIT_LE[3]) &&
                    ($past(oe_n, 3) == EXIT_OE[2]) && ($past(le, 3) == EXIT_LE[2]) &&
                    ($past(oe_n, 2) == EXIT_OE[1]) && ($past(le, 2) == EXIT_LE[1]) &&
                    ($past(oe_n, 1) == EXIT_OE[0]) && ($past(le, 1) == EXIT_LE[0]));
        end
    endgenerate

endmodule

bind pin_key_mode_detector key_mode_checker #(
    .KEY_LEN  (KEY_LEN),
    .ENTER_OE (ENTER_OE),
    .ENTER_LE (ENTER_LE),
    .EXIT_OE  (EXIT_OE),
    .EXIT_LE  (EXIT_LE)
) u_key_mode_checker (
    .clk         (clk),
    .rst         (rst),
    .oe_n        (oe_n),
    .le          (le),
    .check_mode  (check_mode),
    .enter_pulse (enter_pulse),
    .leave_pulse (leave_pulse)
);

// File: tb/test_pin_key_mode_detector.sv
module test_pin_key_mode_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic oe_n = 1'b1;
    logic le = 1'b0;
    logic check_mode;
    logic enter_pulse;
    logic leave_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Keys from R2 and R4, first sample first.
    localparam logic ENT_OE [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic ENT_LE [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic EXT_OE [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic EXT_LE [5] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

    always #5 clk = ~clk;

    pin_key_mode_detector i_pin_key_mode_detector (
        .clk         (clk),
        .rst         (rst),
        .oe_n        (oe_n),
        .le          (le),
        .check_mode  (check_mode),
        .enter_pulse (enter_pulse),
        .leave_pulse (leave_pulse)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        oe_n = 1'b1;
        le   = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one pin sample, let one rising edge take it, then check outputs.
    task automatic step(input logic s_oe, input logic s_le, input logic exp_mode,
                        input logic exp_en, input logic exp_lv, input string tag);
        @(negedge clk);
        oe_n = s_oe;
        le   = s_le;
        @(posedge clk);
        #2;
        chk({tag, " mode"},  check_mode,  exp_mode);
        chk({tag, " enter"}, enter_pulse, exp_en);
        chk({tag, " leave"}, leave_pulse, exp_lv);
        chk({tag, " R9 pulses exclusive"}, enter_pulse & leave_pulse, 1'b0);
    endtask

    task automatic enter_key(input string tag);
        for (int i = 0; i < 5; i++)
            step(ENT_OE[i], ENT_LE[i], (i == 4), (i == 4), 1'b0, tag);
    endtask

    task automatic t_reset();
        do_reset();
        #2;
        chk("R1 reset mode",  check_mode,  1'b0);
        chk("R1 reset enter", enter_pulse, 1'b0);
        chk("R1 reset leave", leave_pulse, 1'b0);
        for (int i = 0; i < 3; i++)
            step(ENT_OE[i], ENT_LE[i], 1'b0, 1'b0, 1'b0, "R1 prefix");
        do_reset();
        for (int i = 3; i < 5; i++)
            step(ENT_OE[i], ENT_LE[i], 1'b0, 1'b0, 1'b0, "R1 tail after reset");
        enter_key("R1 fresh key");
    endtask

    task automatic t_enter();
        do_reset();
        enter_key("R2 entry");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 pulse ends");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 mode held");
    endtask

    task automatic t_exit_in_normal();
        do_reset();
        for (int i = 0; i < 5; i++)
            step(EXT_OE[i], EXT_LE[i], 1'b0, 1'b0, 1'b0, "R5 exit key in normal");
        for (int i = 0; i < 5; i++)
            step(EXT_OE[i], EXT_LE[i], 1'b0, 1'b0, 1'b0, "R5 repeated");
    endtask

    task automatic t_exit();
        do_reset();
        enter_key("R4 setup");
        for (int i = 0; i < 5; i++)
            step(EXT_OE[i], EXT_LE[i], (i != 4), 1'b0, (i == 4), "R4 exit");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 pulse ends");
    endtask

    task automatic t_enter_in_check();
        do_reset();
        enter_key("R6 setup");
        for (int i = 0; i < 5; i++)
            step(ENT_OE[i], ENT_LE[i], 1'b1, 1'b0, 1'b0, "R6 entry key in check");
        for (int i = 0; i < 5; i++)
            step(EXT_OE[i], EXT_LE[i], (i != 4), 1'b0, (i == 4), "R6 exit afterwards");
    endtask

    task automatic t_restart();
        logic so [8] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
        logic sl [8] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
        do_reset();
        for (int i = 0; i < 8; i++)
            step(so[i], sl[i], (i == 7), (i == 7), 1'b0, "R7 restart");
    endtask

    task automatic t_flush();
        do_reset();
        enter_key("R8 setup");
        for (int i = 1; i < 5; i++)
            step(EXT_OE[i], EXT_LE[i], 1'b1, 1'b0, 1'b0, "R8 stale tail");
        for (int i = 0; i < 5; i++)
            step(EXT_OE[i], EXT_LE[i], (i != 4), 1'b0, (i == 4), "R8 fresh exit");
    endtask

    initial begin
        t_reset();
        t_enter();
        t_exit_in_normal();
        t_exit();
        t_enter_in_check();
        t_restart();
        t_flush();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule